// File: doc/BRIEF.md
# Wait-State Memory Responder

This block is a word-wide memory slave for a small stack processor. It holds the processor's program, data and stack in one synchronous word array. The master sends a read or a write as a strobe that lasts one clock, with an address and, for writes, the data. The responder answers through a busy flag, not through a ready/valid pair. Busy goes high one cycle after the strobe and stays high for a fixed number of wait cycles set by a parameter. When busy drops, the access is finished. For a read, the data is on the output in that first cycle with busy low, and it stays there until the next read completes.

The block has three parts. A two-state controller (`ST_IDLE`, `ST_WAIT`) takes each legal strobe and counts out the wait period. The word array performs the access when that period ends. A protocol monitor raises a sticky error flag if the master breaks the handshake.

The controller has four transitions:
- `ST_IDLE -> ST_WAIT` happens on an accepted strobe when the wait count is non-zero.
- `ST_WAIT -> ST_WAIT` happens while the counter is above one.
- `ST_WAIT -> ST_IDLE` happens when the last wait cycle ends, and the access is performed on that edge.
- `ST_IDLE -> ST_IDLE` happens when there is no strobe, on a collision, or on an accepted strobe with a wait count of zero. In the zero-wait case the access is performed at once.

Addresses are byte addresses. Only the word-index bits select a word.

Top module: `wait_state_mem`

## Requirements
- R1: Synchronous reset drives busy, err and rdata to 0. It leaves the contents of the word array unchanged.
- R2: After an accepted strobe in cycle T, busy is low in cycle T itself. Busy is high in cycles T+1 through T+WAIT_CYC and low again in cycle T+WAIT_CYC+1. With WAIT_CYC = 0, busy never rises.
- R3: A read accepted in cycle T presents the addressed word on rdata from cycle T+WAIT_CYC+1. rdata holds that value until a later read completes.
- R4: The address and write data are sampled only in the strobe cycle. Changes to them during the wait cycles have no effect on the access.
- R5: A write is stored by the end of its wait period. A read strobed in the first cycle with busy low returns the new word.
- R6: The word index is addr[BSEL+IDX_W-1:BSEL], where BSEL = log2(DATA_W/8). The byte-select bits below the index and all address bits above it are ignored.
- R7: A strobe while busy is high does not start an access, does not change the array and does not extend the busy period. It sets err.
- R8: A read strobe and a write strobe in the same cycle form a collision. Neither access is performed, busy does not rise, and err is set in the next cycle.
- R9: Once set, err stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_stb | input | 1 | One-cycle read request |
| wr_stb | input | 1 | One-cycle write request |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data, sampled with wr_stb |
| busy | output | 1 | Responder is serving an access |
| rdata | output | DATA_W | Read data, valid once busy is low after a read |
| err | output | 1 | Sticky protocol error flag |

## Verification
The bench runs a reference model with WAIT_CYC = 3 and compares busy, rdata and err on every falling clock edge.

Each output is due at a fixed cycle after the strobe in cycle T:
- busy is expected high for cycles T+1 to T+3.
- Read data is expected from cycle T+4.
- err is expected one cycle after the offending strobe.

The model advances on the same rising edge as the design. Its expected values are therefore aligned with the design's registered outputs, and every check samples half a period after the edge. Directed checks on the read data and the error flag are made at the falling edge of the first cycle with busy low. This is the cycle in which the results become valid.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } wsm_state_e;

endpackage

// File: rtl/wsm_ctrl.sv
module wsm_ctrl
    import wsm_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 8,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              acc_en,
    output logic              acc_we,
    output logic [IDX_W-1:0]  acc_idx,
    output logic [DATA_W-1:0] acc_wdata
);

    localparam int CNT_W = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);

    wsm_state_e        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic              pend_we;
    logic [IDX_W-1:0]  pend_idx;
    logic [DATA_W-1:0] pend_wdata;
    logic              accept;
    logic              last_wait;

    // a strobe is taken only when idle and not a collision
    assign accept    = (state == ST_IDLE) && (rd_stb ^ wr_stb);
    assign last_wait = (state == ST_WAIT) && (cnt == CNT_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept && (WAIT_CYC != 0)) state_nx = ST_WAIT;
            ST_WAIT: if (cnt == CNT_W'(1))          state_nx = ST_IDLE;
        endcase
    end

    // state register and the request captured with the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            pend_we    <= 1'b0;
            pend_idx   <= '0;
            pend_wdata <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cnt        <= CNT_W'(WAIT_CYC);
                pend_we    <= wr_stb;
                pend_idx   <= idx;
                pend_wdata <= wdata;
            end else if (state == ST_WAIT) begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // outputs of the controller
    generate
        if (WAIT_CYC == 0) begin : g_zero_wait
            always_comb begin
                busy      = 1'b0;
                acc_en    = accept;
                acc_we    = wr_stb;
                acc_idx   = idx;
                acc_wdata = wdata;
            end
        end else begin : g_wait
            always_comb begin
                busy      = (state == ST_WAIT);
                acc_en    = last_wait;
                acc_we    = pend_we;
                acc_idx   = pend_idx;
                acc_wdata = pend_wdata;
            end
        end
    endgenerate

    // run length of the current busy period, for the checks below
    logic [CNT_W:0] busy_run;
    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= '0;
        else              busy_run <= busy_run + 1'b1;
    end

    a_r2_busy_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(rd_stb || wr_stb));

    a_r2_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(busy_run) < WAIT_CYC));

    a_r2_busy_drops: assert property (@(posedge clk) disable iff (rst)
        (busy && (int'(busy_run) == WAIT_CYC - 1)) |=> !busy);

    a_r7_no_access_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !acc_en) |=> (busy || $past(acc_en) || !acc_en));

    generate
        if (WAIT_CYC == 0) begin : g_zero_chk
            a_r2_never_busy: assert property (@(posedge clk) disable iff (rst) !busy);
        end
    endgenerate

endmodule

// File: rtl/wsm_array.sv
module wsm_array #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] mem [WORDS];

    // contents are never touched by reset
    always_ff @(posedge clk) begin
        if (acc_en && acc_we) mem[acc_idx] <= acc_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                    rdata <= '0;
        else if (acc_en && !acc_we) rdata <= mem[acc_idx];
    end

    a_r3_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !(acc_en && !acc_we) |=> $stable(rdata));

endmodule

// File: rtl/wsm_err_mon.sv
module wsm_err_mon (
    input  logic clk,
    input  logic rst,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic busy,
    output logic err
);

    logic violation;

    assign violation = (rd_stb && wr_stb) || (busy && (rd_stb || wr_stb));

    always_ff @(posedge clk) begin
        if (rst)            err <= 1'b0;
        else if (violation) err <= 1'b1;
    end

    a_r8_collision_flag: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && wr_stb) |=> err);

    a_r7_busy_strobe_flag: assert property (@(posedge clk) disable iff (rst)
        (busy && (rd_stb || wr_stb)) |=> err);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/wait_state_mem.sv
module wait_state_mem #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 8,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    localparam int BSEL = $clog2(DATA_W / 8);
    localparam int TOPB = BSEL + IDX_W;

    logic [IDX_W-1:0]  idx;
    logic              acc_en;
    logic              acc_we;
    logic [IDX_W-1:0]  acc_idx;
    logic [DATA_W-1:0] acc_wdata;
    logic              unused_addr_bits;

    assign idx              = addr[BSEL +: IDX_W];
    assign unused_addr_bits = ^{addr[ADDR_W-1:TOPB], addr[BSEL-1:0]};

    wsm_ctrl #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .WAIT_CYC (WAIT_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .idx       (idx),
        .wdata     (wdata),
        .busy      (busy),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_idx   (acc_idx),
        .acc_wdata (acc_wdata)
    );

    wsm_array #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_idx   (acc_idx),
        .acc_wdata (acc_wdata),
        .rdata     (rdata)
    );

    wsm_err_mon u_err (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .busy   (busy),
        .err    (err)
    );

    a_r8_no_busy_on_collision: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && wr_stb && !busy) |=> !busy);

endmodule

// File: tb/tb_wait_state_mem.sv
module tb_wait_state_mem;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        busy;
    logic [31:0] rdata;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    logic [31:0] mmem [256];
    int          m_cnt = 0;
    logic [31:0] m_rdata = '0;
    logic        m_err = 1'b0;
    logic        p_we;
    logic [7:0]  p_idx;
    logic [31:0] p_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    wait_state_mem #(.DATA_W(32), .ADDR_W(16), .IDX_W(8), .WAIT_CYC(W)) dut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .busy(busy), .rdata(rdata), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic perform();
        if (p_we) mmem[p_idx] = p_data;
        else      m_rdata = mmem[p_idx];
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_cnt = 0; m_rdata = '0; m_err = 1'b0;
        end else if (m_cnt > 0) begin
            if (rd_stb || wr_stb) m_err = 1'b1;
            m_cnt--;
            if (m_cnt == 0) perform();
        end else if (rd_stb && wr_stb) begin
            m_err = 1'b1;
        end else if (rd_stb || wr_stb) begin
            p_we = wr_stb; p_idx = addr[9:2]; p_data = wdata;
            if (W == 0) perform();
            else        m_cnt = W;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 busy", {31'd0, busy}, {31'd0, (m_cnt != 0)});
            chk("R3 rdata", rdata, m_rdata);
            chk("R9 err", {31'd0, err}, {31'd0, m_err});
        end
    end

    task automatic wait_idle();
        while (m_cnt != 0) @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        wr_stb = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0; addr = ~a; wdata = ~d;
        wait_idle();
    endtask

    task automatic do_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
        rd_stb = 1'b1; addr = a;
        @(negedge clk);
        rd_stb = 1'b0; addr = ~a;
        chk({tag, " busy after strobe"}, {31'd0, busy}, 32'd1);
        wait_idle();
        chk(tag, rdata, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy reset", {31'd0, busy}, 32'd0);
        chk("R1 err reset", {31'd0, err}, 32'd0);
        chk("R1 rdata reset", rdata, 32'd0);
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5000000 ^ (i * 32'h01010101) ^ 32'h00C3;
    endfunction

    initial begin
        @(negedge clk);
        do_reset();

        // R5: load words through the port, read each back
        for (int i = 0; i < 16; i++) do_write(16'(i * 4), pat(i));
        for (int i = 0; i < 16; i++) do_read(16'(i * 4), pat(i), "R3 readback");

        // R5: read strobed on the first idle cycle after a write
        do_write(16'h0024, 32'hDEADBEEF);
        do_read(16'h0024, 32'hDEADBEEF, "R5 write then read");

        // R4: do_write scrambles addr/wdata during the wait cycles
        do_write(16'h0028, 32'h12345678);
        do_read(16'h0028, 32'h12345678, "R4 sampled at strobe");
        do_read(16'h0014, pat(5), "R4 neighbour untouched");

        // R6: byte-select and upper bits ignored
        do_read(16'h001F, pat(7), "R6 low bits");
        do_read(16'h401C, pat(7), "R6 high bits");

        // R7: write strobe while busy is ignored and flagged
        rd_stb = 1'b1; addr = 16'h0018;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b1; addr = 16'h0030; wdata = 32'h0BADF00D;
        @(negedge clk);
        wr_stb = 1'b0;
        wait_idle();
        chk("R7 err set", {31'd0, err}, 32'd1);
        chk("R7 read unaffected", rdata, pat(6));
        do_read(16'h0030, pat(12), "R7 array unchanged");

        // R1: reset clears err, contents survive
        @(negedge clk);
        do_reset();
        do_read(16'h0008, pat(2), "R1 contents kept");

        // R8: collision
        rd_stb = 1'b1; wr_stb = 1'b1; addr = 16'h0034; wdata = 32'hFFFF0000;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        chk("R8 no busy", {31'd0, busy}, 32'd0);
        chk("R8 err set", {31'd0, err}, 32'd1);
        chk("R8 rdata held", rdata, pat(2));
        do_read(16'h0034, pat(13), "R8 array unchanged");
        repeat (20) @(negedge clk);
        chk("R9 err still set", {31'd0, err}, 32'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        done = 1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule